// File: doc/BRIEF.md
# Flash Status Polling Engine

This block runs on the host side of a parallel flash. It decides when a program or erase operation inside the flash has finished. The host first issues the program or erase command by its own means. It then pulses `start` with the address being worked on, the word expected once the operation is over, a method select and a poll budget. The engine reads that address over and over through a request/ready read port and interprets the status bits each read returns.

Two interpretations are available. In polarity mode the engine compares bit 7 of each read with bit 7 of the expected word. In toggle mode it compares bit 6 of consecutive reads. Bit 5 of a read is the device's internal time-limit flag. When the engine sees it, it does not give up at once: it takes one or two further reads, because the other status bits can settle in the same instant as bit 5. When the engine detects completion, it verifies the full word, so an erase is only accepted when the final read returns all ones. On any failure the engine first sends a reset command to the device, so that the device returns to array reads. Only then does it report the failure.

Top module: `pollq_engine`

## Requirements
- R1: A `start` pulse seen while `busy` is low latches the address, expected word, mode (`start_mode` 0 = polarity, 1 = toggle) and budget. The engine then holds `rd_req` with `rd_addr` equal to the latched address until a read completes. Each cycle with `rd_req` and `rd_ready` both high is one read, and `poll_count` equals the number of reads since the accepted start. A `start` pulse while busy is ignored.
- R2: Polarity mode: a read whose bit 7 equals bit 7 of the expected word ends polling as a completion.
- R3: Polarity mode: a read whose bit 7 differs and whose bit 5 is 1 causes exactly one further read. That read ends polling as a completion if its bit 7 matches, and as a failure otherwise.
- R4: Toggle mode: the first read is only recorded. Each later read is compared with the read before it, and an unchanged bit 6 ends polling as a completion.
- R5: Toggle mode: a read whose bit 6 changed and whose bit 5 is 1 causes two further reads, which are judged only against each other. A changed bit 6 between them is a failure, and an unchanged one is a completion.
- R6: A completion is reported as `done` only if the full read word equals the expected word (all ones, 8'hFF, after an erase). Otherwise it is a failure.
- R7: If a read in the normal phase gives no verdict, arms no further read, and brings the read count to at least `max_polls`, polling ends as a failure with `timeout`. Reads armed by bit 5 are exempt from the budget.
- R8: On any failure the engine drops `rd_req`, raises `rstcmd_req` and holds it until `rstcmd_ack`. `fail` pulses in the cycle after the acknowledge.
- R9: `busy` is high from the cycle after an accepted start until the cycle in which the outcome appears. Exactly one of `done` or `fail` then pulses for one cycle. `timeout` pulses only together with `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted when idle) |
| start_addr | input | AW | Address to poll |
| start_expect | input | DW | Word expected at completion |
| start_mode | input | 1 | 0 = polarity method, 1 = toggle method |
| max_polls | input | CW | Read budget for the normal phase |
| rd_req | output | 1 | Read request, held until accepted |
| rd_addr | output | AW | Read address |
| rd_ready | input | 1 | Read completes this cycle; rd_data valid |
| rd_data | input | DW | Read data |
| rstcmd_req | output | 1 | Request to send the device reset command |
| rstcmd_ack | input | 1 | Reset command has been sent |
| busy | output | 1 | Polling or resetting in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | One-cycle failure pulse |
| timeout | output | 1 | Marks a failure caused by the read budget |
| poll_count | output | CW | Reads taken since the last accepted start |

## Verification
The embedded assertions watch, on every cycle, the properties that do not depend on data: the outcome pulses are one cycle wide and never coincide, `timeout` never appears without `fail`, the reset-command request is held until acknowledged and excludes reads, `fail` follows an acknowledge, the read address is stable while a request waits, and the read counter steps by one per accepted read. Whether the status decoding reaches the right verdict can only be shown by the bench's scenarios. These include bit 5 arriving before, with or after settling, the extra reads after bit 5, the full-word verify, and the budget boundary. The bench sweeps the settle point against the bit-5 onset in both modes, with and without read-port stalls.

// File: rtl/pollq_pkg.sv
package pollq_pkg;

    typedef enum logic {
        PM_DATA   = 1'b0,
        PM_TOGGLE = 1'b1
    } poll_mode_e;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_NORM,
        PH_RE1,
        PH_RE2
    } poll_phase_e;

    typedef enum logic [1:0] {
        V_CONT,
        V_DONE,
        V_FAIL
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_POLL,
        ST_RSTC
    } ctl_state_e;

    // status bit positions within a read word
    localparam int unsigned POLARITY_BIT = 7;
    localparam int unsigned TOGGLE_BIT   = 6;
    localparam int unsigned LIMIT_BIT    = 5;

    function automatic verdict_e settle(input logic word_match);
        return word_match ? V_DONE : V_FAIL;
    endfunction

    function automatic logic is_normal(input poll_phase_e ph);
        return (ph == PH_FIRST) || (ph == PH_NORM);
    endfunction

endpackage

// File: rtl/pollq_judge.sv
module pollq_judge
    import pollq_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  poll_mode_e          mode,
    input  poll_phase_e         phase,
    input  logic [DW-1:0]       word,
    input  logic [DW-1:0]       prev_word,
    input  logic [DW-1:0]       expect_word,
    output verdict_e            verdict,
    output poll_phase_e         phase_nxt,
    output logic                expirable
);

    logic full_match;
    logic pol_match;
    logic tgl_still;
    logic lim_seen;

    always_comb begin
        full_match = (word == expect_word);
        pol_match  = (word[POLARITY_BIT] == expect_word[POLARITY_BIT]);
        tgl_still  = (word[TOGGLE_BIT] == prev_word[TOGGLE_BIT]);
        lim_seen   = word[LIMIT_BIT];

        verdict   = V_CONT;
        phase_nxt = phase;

        if (mode == PM_DATA) begin
            if (phase == PH_RE2) begin
                verdict = pol_match ? settle(full_match) : V_FAIL;
            end else if (pol_match) begin
                verdict = settle(full_match);
            end else if (lim_seen) begin
                phase_nxt = PH_RE2;
            end else begin
                phase_nxt = PH_NORM;
            end
        end else begin
            case (phase)
                PH_FIRST: phase_nxt = PH_NORM;
                PH_NORM: begin
                    if (tgl_still) begin
                        verdict = settle(full_match);
                    end else if (lim_seen) begin
                        phase_nxt = PH_RE1;
                    end
                end
                PH_RE1:  phase_nxt = PH_RE2;
                default: verdict = tgl_still ? settle(full_match) : V_FAIL;
            endcase
        end

        expirable = (verdict == V_CONT) && is_normal(phase) && is_normal(phase_nxt);
    end

endmodule

// File: rtl/pollq_ctrl.sv
module pollq_ctrl
    import pollq_pkg::*;
#(
    parameter int unsigned AW = 22,
    parameter int unsigned DW = 8,
    parameter int unsigned CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [AW-1:0]   start_addr,
    input  logic [DW-1:0]   start_expect,
    input  logic            start_mode,
    input  logic [CW-1:0]   max_polls,
    output logic            rd_req,
    output logic [AW-1:0]   rd_addr,
    input  logic            rd_ready,
    input  logic [DW-1:0]   rd_data,
    output logic            rstcmd_req,
    input  logic            rstcmd_ack,
    input  verdict_e        verdict,
    input  poll_phase_e     phase_nxt,
    input  logic            expirable,
    output poll_mode_e      mode,
    output poll_phase_e     phase,
    output logic [DW-1:0]   prev_word,
    output logic [DW-1:0]   expect_word,
    output logic            busy,
    output logic            done,
    output logic            fail,
    output logic            timeout,
    output logic [CW-1:0]   poll_count
);

    localparam int unsigned CW1 = CW + 1;

    ctl_state_e       state;
    logic [AW-1:0]    addr_q;
    logic [CW-1:0]    max_q;
    logic             tmo_pend;
    logic [CW1-1:0]   cnt_inc;
    logic             budget_hit;
    logic             take;

    assign cnt_inc    = {1'b0, poll_count} + CW1'(1);
    assign budget_hit = cnt_inc >= {1'b0, max_q};
    assign take       = (state == ST_POLL) && rd_ready;

    assign rd_req     = (state == ST_POLL);
    assign rd_addr    = addr_q;
    assign rstcmd_req = (state == ST_RSTC);
    assign busy       = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            addr_q      <= '0;
            max_q       <= '0;
            mode        <= PM_DATA;
            phase       <= PH_FIRST;
            prev_word   <= '0;
            expect_word <= '0;
            poll_count  <= '0;
            tmo_pend    <= 1'b0;
            done        <= 1'b0;
            fail        <= 1'b0;
            timeout     <= 1'b0;
        end else begin
            done    <= 1'b0;
            fail    <= 1'b0;
            timeout <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        addr_q      <= start_addr;
                        expect_word <= start_expect;
                        mode        <= poll_mode_e'(start_mode);
                        max_q       <= max_polls;
                        phase       <= PH_FIRST;
                        poll_count  <= '0;
                        tmo_pend    <= 1'b0;
                        state       <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (take) begin
                        if (!cnt_inc[CW]) poll_count <= cnt_inc[CW-1:0];
                        prev_word <= rd_data;
                        if (verdict == V_DONE) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else if (verdict == V_FAIL) begin
                            state <= ST_RSTC;
                        end else if (expirable && budget_hit) begin
                            tmo_pend <= 1'b1;
                            state    <= ST_RSTC;
                        end else begin
                            phase <= phase_nxt;
                        end
                    end
                end
                default: begin
                    if (rstcmd_ack) begin
                        fail    <= 1'b1;
                        timeout <= tmo_pend;
                        state   <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_fail_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        fail |=> !fail);

    p_timeout_with_fail_r7: assert property (@(posedge clk) disable iff (rst)
        timeout |-> fail);

    p_rstcmd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (rstcmd_req && !rstcmd_ack) |=> rstcmd_req);

    p_no_read_in_reset_r8: assert property (@(posedge clk) disable iff (rst)
        rstcmd_req |-> !rd_req);

    p_fail_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
        fail |-> $past(rstcmd_ack));

    p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ready && !(&poll_count)) |=> (poll_count == $past(poll_count) + 1'b1));

endmodule

// File: rtl/pollq_engine.sv
module pollq_engine
    import pollq_pkg::*;
#(
    parameter int unsigned AW = 22,
    parameter int unsigned DW = 8,
    parameter int unsigned CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [AW-1:0]   start_addr,
    input  logic [DW-1:0]   start_expect,
    input  logic            start_mode,
    input  logic [CW-1:0]   max_polls,
    output logic            rd_req,
    output logic [AW-1:0]   rd_addr,
    input  logic            rd_ready,
    input  logic [DW-1:0]   rd_data,
    output logic            rstcmd_req,
    input  logic            rstcmd_ack,
    output logic            busy,
    output logic            done,
    output logic            fail,
    output logic            timeout,
    output logic [CW-1:0]   poll_count
);

    verdict_e       verdict;
    poll_phase_e    phase_nxt;
    poll_phase_e    phase;
    poll_mode_e     mode;
    logic           expirable;
    logic [DW-1:0]  prev_word;
    logic [DW-1:0]  expect_word;

    pollq_judge #(.DW(DW)) u_judge (
        .mode        (mode),
        .phase       (phase),
        .word        (rd_data),
        .prev_word   (prev_word),
        .expect_word (expect_word),
        .verdict     (verdict),
        .phase_nxt   (phase_nxt),
        .expirable   (expirable)
    );

    pollq_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_addr   (start_addr),
        .start_expect (start_expect),
        .start_mode   (start_mode),
        .max_polls    (max_polls),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .rd_ready     (rd_ready),
        .rd_data      (rd_data),
        .rstcmd_req   (rstcmd_req),
        .rstcmd_ack   (rstcmd_ack),
        .verdict      (verdict),
        .phase_nxt    (phase_nxt),
        .expirable    (expirable),
        .mode         (mode),
        .phase        (phase),
        .prev_word    (prev_word),
        .expect_word  (expect_word),
        .busy         (busy),
        .done         (done),
        .fail         (fail),
        .timeout      (timeout),
        .poll_count   (poll_count)
    );

endmodule

// File: tb/pollq_engine_bench.sv
`timescale 1ns/1ps
module pollq_engine_bench;

    localparam int AW = 22;
    localparam int DW = 8;
    localparam int CW = 16;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [AW-1:0]  start_addr = '0;
    logic [DW-1:0]  start_expect = '0;
    logic           start_mode = 1'b0;
    logic [CW-1:0]  max_polls = '0;
    logic           rd_req;
    logic [AW-1:0]  rd_addr;
    logic           rd_ready = 1'b0;
    logic [DW-1:0]  rd_data = '0;
    logic           rstcmd_req;
    logic           rstcmd_ack = 1'b0;
    logic           busy, done, fail, timeout;
    logic [CW-1:0]  poll_count;

    int errors = 0;
    int checks = 0;
    logic [7:0] seq [32];
    int fidx = 0;
    int fbase = 0;
    int ncyc = 0;
    int acnt = 0;
    int rst_seen = 0;
    logic stall = 1'b0;

    always #2 clk = ~clk;

    pollq_engine #(.AW(AW), .DW(DW), .CW(CW)) u_pollq_engine (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_expect(start_expect), .start_mode(start_mode), .max_polls(max_polls),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .rstcmd_req(rstcmd_req), .rstcmd_ack(rstcmd_ack), .busy(busy), .done(done),
        .fail(fail), .timeout(timeout), .poll_count(poll_count)
    );

    // flash read port model: a read offered at a falling edge is taken at the next rising edge
    always @(negedge clk) begin
        int k;
        if (rd_ready) fidx++;
        ncyc++;
        k = fidx - fbase;
        if (k > 31) k = 31;
        if (k < 0) k = 0;
        if (rd_req && (!stall || (ncyc % 2 == 1))) begin
            rd_ready = 1'b1;
            rd_data  = seq[k];
        end else begin
            rd_ready = 1'b0;
        end
    end

    // reset command path: acknowledge after two cycles of request
    always @(negedge clk) begin
        if (rstcmd_req) rst_seen++;
        if (rstcmd_req && !rstcmd_ack) begin
            acnt++;
            if (acnt >= 2) begin
                rstcmd_ack = 1'b1;
                acnt = 0;
            end
        end else begin
            rstcmd_ack = 1'b0;
        end
    end

    initial begin
        #600000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // reference verdict computed from the requirements
    function automatic void model(input logic md, input logic [7:0] e, input int mx,
                                  output int od, output int of, output int ot, output int oc);
        int ph;
        logic [7:0] w;
        logic [7:0] pv;
        od = 0; of = 0; ot = 0; oc = 0; ph = 0; pv = '0;
        for (int i = 0; i < 32; i++) begin
            w = seq[i];
            oc++;
            if (!md) begin
                if (ph == 2) begin
                    if (w[7] == e[7] && w == e) od = 1; else of = 1;
                    return;
                end
                if (w[7] == e[7]) begin
                    if (w == e) od = 1; else of = 1;
                    return;
                end
                if (w[5]) ph = 2;
                else if (oc >= mx) begin of = 1; ot = 1; return; end
            end else begin
                if (ph == 0) begin
                    ph = 1;
                    if (oc >= mx) begin of = 1; ot = 1; return; end
                end else if (ph == 1) begin
                    if (w[6] == pv[6]) begin
                        if (w == e) od = 1; else of = 1;
                        return;
                    end else if (w[5]) ph = 3;
                    else if (oc >= mx) begin of = 1; ot = 1; return; end
                end else if (ph == 3) begin
                    ph = 4;
                end else begin
                    if (w[6] == pv[6] && w == e) od = 1; else of = 1;
                    return;
                end
            end
            pv = w;
        end
    endfunction

    int last_done, last_fail, last_tmo, last_cnt;

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 32; i++) seq[i] = v;
    endtask

    task automatic run(input logic md, input logic [7:0] e, input int mx,
                       input logic [AW-1:0] a, input logic stl, input logic poke);
        int od, of, ot, oc, r0, w;
        model(md, e, mx, od, of, ot, oc);
        @(negedge clk);
        @(negedge clk);
        fbase = fidx;
        stall = stl;
        r0 = rst_seen;
        start = 1'b1; start_mode = md; start_expect = e;
        max_polls = CW'(mx); start_addr = a;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        w = 0;
        while (!(done || fail) && w < 300) begin
            if (rd_req) chk(rd_addr == a, "R1 read address", rd_addr, a);
            if (poke && w == 1) begin start = 1'b1; start_addr = ~a; start_mode = ~md; end
            if (poke && w == 2) start = 1'b0;
            @(negedge clk);
            w++;
        end
        chk(w < 300, "R9 outcome reached", w, 0);
        chk(done == od[0], md ? "R4/R5 done verdict" : "R2/R3 done verdict", done, od);
        chk(fail == of[0], md ? "R4/R5 fail verdict" : "R2/R3 fail verdict", fail, of);
        chk(timeout == ot[0], "R7 timeout flag", timeout, ot);
        chk(poll_count == CW'(oc), "R1 read count", poll_count, oc);
        chk((rst_seen != r0) == of[0], "R8 reset command on failure", rst_seen - r0, of);
        chk(busy == 1'b0, "R9 busy falls with outcome", busy, 0);
        last_done = done; last_fail = fail; last_tmo = timeout; last_cnt = poll_count;
        @(negedge clk);
        chk(!done && !fail, "R9 single-cycle pulse", {done, fail}, 0);
    endtask

    task automatic expect_res(input string tag, input int d, input int f, input int t, input int c);
        chk(last_done == d, tag, last_done, d);
        chk(last_fail == f, tag, last_fail, f);
        chk(last_tmo == t, tag, last_tmo, t);
        chk(last_cnt == c, tag, last_cnt, c);
    endtask

    initial begin
        logic [7:0] e;
        logic [7:0] s;
        fill(8'h00);
        repeat (3) @(negedge clk);
        chk(!done && !fail && !busy && !rd_req && !rstcmd_req && poll_count == 0,
            "R9 reset state", {done, fail, busy, rd_req, rstcmd_req}, 0);
        rst = 1'b0;

        // R2: first read already settled
        fill(8'hC3);
        run(1'b0, 8'hC3, 12, 22'h000100, 1'b0, 1'b0);
        expect_res("R2 immediate completion", 1, 0, 0, 1);

        // R6: erase accepted only at all ones
        fill(8'hFF); seq[0] = 8'h00;
        run(1'b0, 8'hFF, 12, 22'h000200, 1'b0, 1'b0);
        expect_res("R6 erase verified", 1, 0, 0, 2);
        fill(8'hFF); seq[0] = 8'h00; seq[1] = 8'hFE;
        run(1'b0, 8'hFF, 12, 22'h000300, 1'b1, 1'b0);
        expect_res("R6 erase verify mismatch", 0, 1, 0, 2);

        // R3: extra read after bit 5, outside the budget
        fill(8'h80); seq[0] = 8'h20;
        run(1'b0, 8'h80, 1, 22'h000400, 1'b0, 1'b0);
        expect_res("R3 recheck settles", 1, 0, 0, 2);
        fill(8'h80); seq[0] = 8'h20; seq[1] = 8'h25;
        run(1'b0, 8'h80, 12, 22'h000500, 1'b0, 1'b0);
        expect_res("R3 recheck fails", 0, 1, 0, 2);

        // R7: budget exhausted
        fill(8'h00);
        run(1'b0, 8'h80, 3, 22'h000600, 1'b1, 1'b0);
        expect_res("R7 budget timeout", 0, 1, 1, 3);

        // R4: toggle settles at the fifth read
        fill(8'h11); seq[0] = 8'h40; seq[1] = 8'h00; seq[2] = 8'h40;
        run(1'b1, 8'h11, 12, 22'h000700, 1'b0, 1'b0);
        expect_res("R4 toggle settles", 1, 0, 0, 5);

        // R5: two reads after bit 5
        fill(8'h00); seq[0] = 8'h40; seq[1] = 8'h20; seq[2] = 8'h40;
        run(1'b1, 8'h00, 12, 22'h000800, 1'b0, 1'b0);
        expect_res("R5 still toggling fails", 0, 1, 0, 4);
        fill(8'h40); seq[0] = 8'h40; seq[1] = 8'h20;
        run(1'b1, 8'h40, 12, 22'h000900, 1'b1, 1'b0);
        expect_res("R5 settles after bit 5", 1, 0, 0, 4);

        // R1: start while busy has no effect
        fill(8'h80);
        for (int i = 0; i < 8; i++) seq[i] = 8'h00;
        run(1'b0, 8'h80, 12, 22'h0ABCDE, 1'b0, 1'b1);
        expect_res("R1 start while busy ignored", 1, 0, 0, 9);

        // polarity sweep: settle point against bit-5 onset
        for (int m = 0; m < 7; m++) begin
            for (int d = 0; d < 8; d++) begin
                e = 8'(m * 53 + d * 29 + 7);
                for (int i = 0; i < 32; i++) begin
                    if (i >= m) begin
                        seq[i] = ((m + d) % 5 == 0 && i == m) ? (e ^ 8'h02) : e;
                    end else begin
                        s = 8'(i * 19 + 3);
                        s[7] = ~e[7];
                        s[5] = (i >= d);
                        seq[i] = s;
                    end
                end
                run(1'b0, e, (d % 3 == 0) ? 3 : 12, AW'(m * 1000 + d), 1'((m + d) % 2), 1'b0);
            end
        end

        // toggle sweep
        for (int t = 0; t < 7; t++) begin
            for (int d = 0; d < 8; d++) begin
                e = 8'(t * 41 + d * 13 + 5);
                for (int i = 0; i < 32; i++) begin
                    if (i >= t) begin
                        seq[i] = ((t + d) % 4 == 1 && i == t) ? (e ^ 8'h08) : e;
                    end else begin
                        s = 8'(i * 23 + 1);
                        s[6] = 1'(i % 2);
                        s[5] = (i >= d);
                        seq[i] = s;
                    end
                end
                run(1'b1, e, (d % 3 == 1) ? 4 : 12, AW'(t * 2000 + d + 7), 1'((t + d) % 2), 1'b0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule